// File: doc/BRIEF.md
# GPIO Configuration Commit Guard

This block holds the configuration state of one 8-pin GPIO port. It has four pin-configuration registers: alternate-function select, pull-up enable, control select and digital enable. Writes to these registers pass through a per-bit commit mask. A pin whose commit bit is clear keeps its configuration bits no matter what software writes. A pin whose commit bit is set takes the written value.

A separate analog-mode register selects the analog function of the upper four pins. The commit mask does not gate it.

The commit mask is fixed at all-ones on ordinary ports. A port built with the `GUARDED` parameter set has one guarded pin, bit `GUARD_PIN`, whose commit bit is the only writable one. That bit resets to zero, so the pin starts locked.

All registers sit on a simple synchronous bus with address, write enable, write data and registered read data. Every register's current value is also driven to the pad logic through dedicated outputs.

Top module: `gpio_commit_bank`

## Requirements
- R1: After reset the four gated registers and the analog register are zero. The commit mask is 0x7F on a guarded port and 0xFF on an ordinary port.
- R2: Word addresses 0, 1, 2 and 3 select alternate function, pull-up, control select and digital enable. When the commit bit is 1, a write to one of these registers loads the written bit.
- R3: When the commit bit is 0, the matching bit of each of the four gated registers keeps its old value on a write.
- R4: On a guarded port, only commit bit `GUARD_PIN` (bit 7) takes the written value at word address 5. All other commit bits ignore writes.
- R5: On an ordinary port, the commit mask stays 0xFF whatever is written to address 5.
- R6: The analog register at word address 4 stores write-data bits 7..4 whatever the commit mask holds. Its bits 3..0 always read as zero.
- R7: Read-data bits 31..8 are zero for every address.
- R8: Read data reflects the register selected by the address one clock edge after the address is presented. It holds its value until the next edge. Addresses 6 and above read as zero.
- R9: The pin outputs show the stored register values from the clock edge that accepts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register word address |
| busWe | input | 1 | Write strobe, acts on the rising clock edge |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| pinAltFn | output | PINS | Alternate-function select per pin |
| pinPullUp | output | PINS | Pull-up enable per pin |
| pinCtlSel | output | PINS | Control select per pin |
| pinDigEn | output | PINS | Digital enable per pin |
| pinAnalog | output | PINS | Analog mode per pin (bits 3..0 zero) |
| pinCommit | output | PINS | Current commit mask |

## Verification
A write is applied at one rising edge. The pin outputs and the stored state are valid from that edge, so the bench drives the write at a falling edge and samples the outputs at the next falling edge.

A read result is due exactly one edge after the address appears. The bench therefore presents the address at a falling edge and samples read data at the following falling edge. It also samples mid-cycle to confirm that a new address has not yet changed the output.

A guarded and an ordinary instance receive the same bus stimulus. Each is compared against its own arithmetic model of the masked-write rule.

// File: rtl/gpio_commit_pkg.sv
package gpio_commit_pkg;

  localparam int unsigned REG_ALT  = 0;
  localparam int unsigned REG_PULL = 1;
  localparam int unsigned REG_CTL  = 2;
  localparam int unsigned REG_DIG  = 3;
  localparam int unsigned REG_ANA  = 4;
  localparam int unsigned REG_CMT  = 5;
  localparam int unsigned NUM_GATED = 4;

  typedef enum logic [2:0] {
    SEL_ALT, SEL_PULL, SEL_CTL, SEL_DIG, SEL_ANA, SEL_CMT, SEL_NONE
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_GATED-1:0] wrCfg;
    logic                 wrAna;
    logic                 wrCmt;
    rdSel_e               rdSel;
  } busStrobe_t;

endpackage

// File: rtl/gpio_commit_ctrl.sv
module gpio_commit_ctrl
  import gpio_commit_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_NONE;
    case (busAddr)
      ADDR_W'(REG_ALT):  begin strobe.rdSel = SEL_ALT;  strobe.wrCfg[REG_ALT]  = busWe; end
      ADDR_W'(REG_PULL): begin strobe.rdSel = SEL_PULL; strobe.wrCfg[REG_PULL] = busWe; end
      ADDR_W'(REG_CTL):  begin strobe.rdSel = SEL_CTL;  strobe.wrCfg[REG_CTL]  = busWe; end
      ADDR_W'(REG_DIG):  begin strobe.rdSel = SEL_DIG;  strobe.wrCfg[REG_DIG]  = busWe; end
      ADDR_W'(REG_ANA):  begin strobe.rdSel = SEL_ANA;  strobe.wrAna = busWe; end
      ADDR_W'(REG_CMT):  begin strobe.rdSel = SEL_CMT;  strobe.wrCmt = busWe; end
      default:           strobe.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_commit_dp.sv
module gpio_commit_dp
  import gpio_commit_pkg::*;
#(
  parameter int unsigned PINS   = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [PINS-1:0] COMMIT_RST = '1,
  parameter logic [PINS-1:0] COMMIT_WR  = '0,
  parameter logic [PINS-1:0] ANA_MASK   = '1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  busStrobe_t                    strobe,
  input  logic [PINS-1:0]               wrData,
  output logic [NUM_GATED-1:0][PINS-1:0] cfgOut,
  output logic [PINS-1:0]               anaOut,
  output logic [PINS-1:0]               cmtOut,
  output logic [DATA_W-1:0]             rdData
);

  logic [DATA_W-1:0] rdNext;

  // commit mask: only COMMIT_WR bits are writable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cmtOut <= COMMIT_RST;
    else if (strobe.wrCmt) cmtOut <= (cmtOut & ~COMMIT_WR) | (wrData & COMMIT_WR);
  end

  // gated configuration registers
  for (genvar g = 0; g < NUM_GATED; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cfgOut[g] <= '0;
      else if (strobe.wrCfg[g]) cfgOut[g] <= (cfgOut[g] & ~cmtOut) | (wrData & cmtOut);
    end
  end

  // analog select, not gated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             anaOut <= '0;
    else if (strobe.wrAna) anaOut <= wrData & ANA_MASK;
  end

  always_comb begin
    rdNext = '0;
    case (strobe.rdSel)
      SEL_ALT:  rdNext = DATA_W'(cfgOut[REG_ALT]);
      SEL_PULL: rdNext = DATA_W'(cfgOut[REG_PULL]);
      SEL_CTL:  rdNext = DATA_W'(cfgOut[REG_CTL]);
      SEL_DIG:  rdNext = DATA_W'(cfgOut[REG_DIG]);
      SEL_ANA:  rdNext = DATA_W'(anaOut);
      SEL_CMT:  rdNext = DATA_W'(cmtOut);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

endmodule

// File: rtl/gpio_commit_bank.sv
module gpio_commit_bank
  import gpio_commit_pkg::*;
#(
  parameter int unsigned PINS       = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter bit          GUARDED    = 1'b1,
  parameter int unsigned GUARD_PIN  = 7,
  parameter int unsigned ANALOG_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [PINS-1:0]   pinAltFn,
  output logic [PINS-1:0]   pinPullUp,
  output logic [PINS-1:0]   pinCtlSel,
  output logic [PINS-1:0]   pinDigEn,
  output logic [PINS-1:0]   pinAnalog,
  output logic [PINS-1:0]   pinCommit
);

  localparam logic [PINS-1:0] GUARD_BIT  = PINS'(1) << GUARD_PIN;
  localparam logic [PINS-1:0] COMMIT_RST = GUARDED ? ~GUARD_BIT : {PINS{1'b1}};
  localparam logic [PINS-1:0] COMMIT_WR  = GUARDED ? GUARD_BIT : {PINS{1'b0}};
  localparam logic [PINS-1:0] ANA_MASK   = {PINS{1'b1}} << ANALOG_LSB;

  busStrobe_t                     strobe;
  logic [NUM_GATED-1:0][PINS-1:0] cfgOut;

  gpio_commit_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe)
  );

  gpio_commit_dp #(
    .PINS(PINS), .DATA_W(DATA_W),
    .COMMIT_RST(COMMIT_RST), .COMMIT_WR(COMMIT_WR), .ANA_MASK(ANA_MASK)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (busWdata[PINS-1:0]),
    .cfgOut (cfgOut),
    .anaOut (pinAnalog),
    .cmtOut (pinCommit),
    .rdData (busRdata)
  );

  assign pinAltFn  = cfgOut[REG_ALT];
  assign pinPullUp = cfgOut[REG_PULL];
  assign pinCtlSel = cfgOut[REG_CTL];
  assign pinDigEn  = cfgOut[REG_DIG];

endmodule

// File: rtl/gpio_commit_bank_chk.sv
module gpio_commit_bank_chk #(
  parameter int unsigned PINS       = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter bit          GUARDED    = 1'b1,
  parameter int unsigned GUARD_PIN  = 7,
  parameter int unsigned ANALOG_LSB = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic [PINS-1:0]   pinAltFn,
  input logic [PINS-1:0]   pinPullUp,
  input logic [PINS-1:0]   pinCtlSel,
  input logic [PINS-1:0]   pinDigEn,
  input logic [PINS-1:0]   pinAnalog,
  input logic [PINS-1:0]   pinCommit
);

  localparam logic [PINS-1:0] WR_OK   = GUARDED ? (PINS'(1) << GUARD_PIN) : {PINS{1'b0}};
  localparam logic [PINS-1:0] ANA_OK  = {PINS{1'b1}} << ANALOG_LSB;

  p_alt_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((pinAltFn ^ $past(pinAltFn)) & ~$past(pinCommit)) == '0);
  p_pull_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((pinPullUp ^ $past(pinPullUp)) & ~$past(pinCommit)) == '0);
  p_ctl_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((pinCtlSel ^ $past(pinCtlSel)) & ~$past(pinCommit)) == '0);
  p_dig_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((pinDigEn ^ $past(pinDigEn)) & ~$past(pinCommit)) == '0);
  p_commit_ro_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((pinCommit ^ $past(pinCommit)) & ~WR_OK) == '0);
  p_analog_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pinAnalog & ~ANA_OK) == '0);
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:PINS] == '0);
  p_analog_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busAddr) == ADDR_W'(4)) |-> (busRdata == DATA_W'($past(pinAnalog))));
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busAddr) > ADDR_W'(5)) |-> (busRdata == '0));

endmodule

bind gpio_commit_bank gpio_commit_bank_chk #(
  .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .GUARDED(GUARDED), .GUARD_PIN(GUARD_PIN), .ANALOG_LSB(ANALOG_LSB)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdata(busRdata),
  .pinAltFn(pinAltFn), .pinPullUp(pinPullUp), .pinCtlSel(pinCtlSel),
  .pinDigEn(pinDigEn), .pinAnalog(pinAnalog), .pinCommit(pinCommit)
);

// File: tb/gpio_commit_bank_tb.sv
module gpio_commit_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdG, rdP;
  logic [7:0]  altG, pullG, ctlG, digG, anaG, cmtG;
  logic [7:0]  altP, pullP, ctlP, digP, anaP, cmtP;

  int total = 0;
  int fails = 0;

  logic [7:0] modG [4];
  logic [7:0] modP [4];
  logic [7:0] mCmtG, mCmtP, mAna;

  always #10 clk = ~clk;

  gpio_commit_bank #(.GUARDED(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(rdG), .pinAltFn(altG), .pinPullUp(pullG), .pinCtlSel(ctlG),
    .pinDigEn(digG), .pinAnalog(anaG), .pinCommit(cmtG)
  );

  gpio_commit_bank #(.GUARDED(1'b0)) dutOpen_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(rdP), .pinAltFn(altP), .pinPullUp(pullP), .pinCtlSel(ctlP),
    .pinDigEn(digP), .pinAnalog(anaP), .pinCommit(cmtP)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // write at a falling edge, accepted at the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    if (a < 4) begin
      modG[a] = (modG[a] & ~mCmtG) | (d[7:0] & mCmtG);
      modP[a] = (modP[a] & ~mCmtP) | (d[7:0] & mCmtP);
    end else if (a == 4) begin
      mAna = d[7:0] & 8'hF0;
    end else if (a == 5) begin
      mCmtG = (mCmtG & 8'h7F) | (d[7:0] & 8'h80);
    end
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pinG(input int r);
    case (r)
      0: return altG; 1: return pullG; 2: return ctlG; default: return digG;
    endcase
  endfunction

  function automatic logic [7:0] pinP(input int r);
    case (r)
      0: return altP; 1: return pullP; 2: return ctlP; default: return digP;
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    chk("watchdog expired", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    for (int r = 0; r < 4; r++) begin modG[r] = '0; modP[r] = '0; end
    mCmtG = 8'h7F; mCmtP = 8'hFF; mAna = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 commit guarded", {24'd0, cmtG}, 32'h7F);
    chk("R1 commit open", {24'd0, cmtP}, 32'hFF);
    chk("R1 cfg zero", {altG, pullG, ctlG, digG}, 32'd0);
    chk("R1 analog zero", {16'd0, anaG, anaP}, 32'd0);
    rd(4'd5);
    chk("R1 commit read guarded", rdG, 32'h7F);
    chk("R1 commit read open", rdP, 32'hFF);

    // R4 R5 commit writes
    wr(4'd5, 32'hFFFF_FF00);
    chk("R5 open commit ignores write", {24'd0, cmtP}, 32'hFF);
    chk("R4 guarded commit low bits", {24'd0, cmtG}, 32'h7F);

    // sweep: phases with guard pin locked, unlocked, relocked
    for (int p = 0; p < 3; p++) begin
      wr(4'd5, (p == 1) ? 32'h0000_0080 : 32'hFFFF_FF7F);
      chk("R4 guarded commit after write", {24'd0, cmtG}, {24'd0, mCmtG});
      chk("R5 open commit steady", {24'd0, cmtP}, 32'hFF);
      for (int r = 0; r < 4; r++) begin
        for (int k = 0; k < 8; k++) begin
          logic [31:0] d;
          d = 32'hC3A5_9600 | 32'((k * 59 + r * 101 + p * 23) % 256);
          wr(4'(r), d);
          // R9 pins valid after accepting edge; R3 locked bits held, R2 loaded
          chk(p == 1 ? "R2 R9 guarded pins" : "R3 R9 guarded pins", {24'd0, pinG(r)}, {24'd0, modG[r]});
          chk("R2 R9 open pins", {24'd0, pinP(r)}, {24'd0, modP[r]});
          rd(4'(r));
          chk("R7 R8 guarded read", rdG, {24'd0, modG[r]});
          chk("R7 R8 open read", rdP, {24'd0, modP[r]});
        end
      end
    end

    // R6 analog, with guard pin locked
    wr(4'd5, 32'h0);
    wr(4'd4, 32'hFFFF_FFFF);
    chk("R6 analog pins guarded", {24'd0, anaG}, 32'hF0);
    rd(4'd4);
    chk("R6 R7 analog read", rdG, 32'hF0);
    chk("R6 R7 analog read open", rdP, 32'hF0);
    wr(4'd4, 32'h0000_005A);
    rd(4'd4);
    chk("R6 analog pattern", rdG, {24'd0, mAna});
    chk("R6 analog pins open", {24'd0, anaP}, 32'h50);

    // R8 unmapped addresses
    for (int a = 6; a < 16; a++) begin
      rd(4'(a));
      chk("R8 unmapped guarded", rdG, 32'd0);
      chk("R8 unmapped open", rdP, 32'd0);
    end

    // R8 latency: value appears only after one edge
    rd(4'd0);
    chk("R8 alt read", rdG, {24'd0, modG[0]});
    busAddr = 4'd9;
    #5;
    chk("R8 read holds before edge", rdG, {24'd0, modG[0]});
    @(negedge clk);
    chk("R8 read after edge", rdG, 32'd0);

    finishRun();
  end

endmodule